// File: doc/BRIEF.md
# Serial NOR Flash Parameter Discovery Engine

This block probes a serial NOR flash part after power-up and works out how software and later hardware should address it. It issues discovery reads over a byte-level SPI command port. Each byte is offered with a request and completed by a byte-done pulse from an external serializer, which also returns the byte that came back. The engine checks the discovery header signature and walks every parameter header. It keeps the newest compatible basic flash parameter table. From that table it reads the page size and the density.

When the walk finishes, the engine reports the page size in bytes, the capacity in bytes and whether the part needs 4-byte addressing. It also returns an error code and pulses a done strobe. If anything goes wrong, the outputs fall back to parameterised defaults, so a caller can always use them. A run is started with a one-cycle start pulse while the engine is idle.

Top module: `sfdp_probe`

## Requirements
- R1: Each dword read is one chip-select window of nine bytes. The bytes are the opcode 0x5A, a 24-bit byte address sent most significant byte first, a dummy byte 0x00, and then four data bytes assembled least significant byte first. A request is never raised without chip select, and chip select drops between reads.
- R2: The dword at address 0 must equal 0x50444653. Otherwise the run ends after that single read with error code 1 and default outputs.
- R3: Header dword 2 (address 4) holds the minor revision in bits [7:0], the major revision in [15:8] and a zero-based header count in [23:16]. Parameter header k (k from 0) is read as two dwords at 8*(k+1) and 8*(k+1)+4. A successful run therefore makes 2 + 2*(count+1) + 2 reads.
- R4: A parameter header describes the basic table only if the main major revision is 1 and its ID low byte (dword 1 bits [7:0]) is 0x00. When the main minor revision is 5 or more, the ID high byte (dword 2 bits [31:24]) must also be 0xFF.
- R5: A basic header is accepted only if its table major revision (dword 1 bits [23:16]) is 1. Its table minor revision (bits [15:8]) must be no lower than the best one accepted so far, so a later equal revision wins and a later lower revision is ignored. The table pointer is dword 2 bits [23:0].
- R6: If no header is accepted, the run ends with error code 2 and default outputs, even after an earlier successful run.
- R7: For a table minor revision below 5, the first table read is table dword 1 (pointer+0). The page size is then 64 when bit 2 is set, else 1. For revision 5 or later, the first table read is table dword 11 (pointer+40). The page size is then 2 to the power of bits [7:4].
- R8: Table dword 2 (pointer+4) gives the density, with N in bits [30:0]. When bit 31 is set, the capacity is 2^(N-3) bytes. An N outside 3..34 ends the run with error code 3 and default outputs. When bit 31 is clear, the capacity is (N+1)/8 bytes.
- R9: The 4-byte addressing flag is set exactly when the reported capacity exceeds 16 MiB; exactly 16 MiB stays in 3-byte mode.
- R10: After reset, the outputs are the defaults with error code 0 and no done. Done is a one-cycle pulse per run, and the outputs change only in the cycle done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a discovery run when idle |
| spi_sel_o | output | 1 | Chip select, high for the whole dword read |
| spi_req_o | output | 1 | Byte transfer request, held until byte done |
| spi_tx_o | output | 8 | Byte to send |
| spi_rx_i | input | 8 | Byte received, valid with spi_done_i |
| spi_done_i | input | 1 | Byte transfer complete |
| done_o | output | 1 | One-cycle end-of-run strobe |
| err_o | output | 2 | 0 ok, 1 bad signature, 2 no table, 3 density overflow |
| page_size_o | output | PAGE_W | Page size in bytes |
| capacity_o | output | 32 | Capacity in bytes |
| addr4_o | output | 1 | 4-byte addressing required |

## Verification
The bench targets the selection rule across several parameter headers. These include a foreign table ID, a major revision of 2, an equal revision that must replace the earlier one and a lower one that must not. A design that used a strict comparison or stopped at the first match would report the wrong table's page size and capacity. The revision split at minor 5 is exercised on both sides. The case with a header-level high ID byte of 0x00 must fail, and the table dword read must move from dword 1 to dword 11; a swapped threshold would show up as a wrong read address and page size. Density limits N=34 and N=35, the exact 16 MiB boundary and the largest linear density catch an off-by-one in the shift, the overflow test or the mode compare. Errors that follow a successful run must restore the defaults rather than keep stale values.

// File: rtl/sfdp_probe_pkg.sv
package sfdp_probe_pkg;

   localparam logic [7:0]  DISC_OPCODE = 8'h5A;
   localparam logic [31:0] DISC_SIG    = 32'h5044_4653;
   localparam logic [7:0]  BASIC_ID_LO = 8'h00;
   localparam logic [7:0]  BASIC_ID_HI = 8'hFF;
   localparam logic [7:0]  REV_SPLIT   = 8'd5;

   typedef enum logic [1:0] {
      PERR_NONE  = 2'd0,
      PERR_SIG   = 2'd1,
      PERR_NOTBL = 2'd2,
      PERR_OVF   = 2'd3
   } probe_err_e;

   typedef enum logic [2:0] {
      PS_IDLE, PS_HDR1, PS_HDR2, PS_PH1, PS_PH2, PS_TPAGE, PS_TDENS
   } probe_st_e;

endpackage

// File: rtl/sfdp_dword_rd.sv
module sfdp_dword_rd
   import sfdp_probe_pkg::*;
#(
   parameter int AW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [AW-1:0] addr_i,
   output logic          sel_o,
   output logic          req_o,
   output logic [7:0]    tx_o,
   input  logic [7:0]    rx_i,
   input  logic          done_i,
   output logic          fin_o,
   output logic [31:0]   dw_o
);
   localparam int AB = AW / 8;
   localparam int D0 = AB + 2;
   localparam int NB = D0 + 4;
   localparam int CW = $clog2(NB);

   if ((AW % 8) != 0 || AW < 8) begin : g_bad_aw
      initial $error("sfdp_dword_rd: AW must be a positive multiple of 8");
   end

   logic          active;
   logic [CW-1:0] bcnt;
   logic [AW-1:0] addr_q;
   logic          last_b;

   assign last_b = (bcnt == CW'(NB - 1));
   assign sel_o  = active;
   assign req_o  = active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         bcnt   <= '0;
         addr_q <= '0;
         fin_o  <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (go_i) begin
            active <= 1'b1;
            bcnt   <= '0;
            addr_q <= addr_i;
         end else if (active && done_i) begin
            bcnt <= bcnt + 1'b1;
            if (last_b) begin
               active <= 1'b0;
               fin_o  <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      tx_o = 8'h00;
      if (bcnt == '0) tx_o = DISC_OPCODE;
      for (int i = 0; i < AB; i++) begin
         if (bcnt == CW'(i + 1)) tx_o = addr_q[AW-8*(i+1) +: 8];
      end
   end

   for (genvar g = 0; g < 4; g++) begin : g_cap
      logic [7:0] b;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      b <= '0;
         else if (active && done_i && bcnt == CW'(D0 + g)) b <= rx_i;
      end
      assign dw_o[8*g +: 8] = b;
   end

endmodule

// File: rtl/sfdp_hdr_eval.sv
module sfdp_hdr_eval
   import sfdp_probe_pkg::*;
(
   input  logic [7:0]  main_major_i,
   input  logic [7:0]  main_minor_i,
   input  logic [23:0] ph_lo_i,
   input  logic [31:0] ph_hi_i,
   input  logic [7:0]  best_minor_i,
   output logic        accept_o,
   output logic [7:0]  tbl_minor_o,
   output logic [23:0] tbl_ptr_o
);
   logic is_basic;
   logic [7:0] tbl_major;

   assign tbl_minor_o = ph_lo_i[15:8];
   assign tbl_major   = ph_lo_i[23:16];
   assign tbl_ptr_o   = ph_hi_i[23:0];

   always_comb begin
      is_basic = 1'b0;
      if (main_major_i == 8'd1) begin
         if (main_minor_i < REV_SPLIT)
            is_basic = (ph_lo_i[7:0] == BASIC_ID_LO);
         else
            is_basic = (ph_lo_i[7:0] == BASIC_ID_LO) && (ph_hi_i[31:24] == BASIC_ID_HI);
      end
   end

   assign accept_o = is_basic && (tbl_major == 8'd1) && (tbl_minor_o >= best_minor_i);

endmodule

// File: rtl/sfdp_bfpt_dec.sv
module sfdp_bfpt_dec
   import sfdp_probe_pkg::*;
#(
   parameter int PAGE_W = 16
) (
   input  logic [7:0]        tbl_minor_i,
   input  logic              gran_i,
   input  logic [3:0]        page_exp_i,
   input  logic [31:0]       dens_i,
   output logic [PAGE_W-1:0] page_o,
   output logic [31:0]       cap_o,
   output logic              ovf_o
);
   if (PAGE_W < 16) begin : g_bad_pw
      initial $error("sfdp_bfpt_dec: PAGE_W must hold 2^15");
   end

   logic [30:0] n;
   assign n = dens_i[30:0];

   always_comb begin
      if (tbl_minor_i < REV_SPLIT)
         page_o = gran_i ? PAGE_W'(64) : PAGE_W'(1);
      else
         page_o = PAGE_W'(1) << page_exp_i;
   end

   always_comb begin
      ovf_o = 1'b0;
      cap_o = '0;
      if (dens_i[31]) begin
         ovf_o = (n < 31'd3) || (n > 31'd34);
         if (!ovf_o) cap_o = 32'd1 << (n[5:0] - 6'd3);
      end else begin
         cap_o = ({1'b0, n} + 32'd1) >> 3;
      end
   end

endmodule

// File: rtl/sfdp_probe.sv
module sfdp_probe
   import sfdp_probe_pkg::*;
#(
   parameter int          PAGE_W     = 16,
   parameter int          DEF_PAGE   = 256,
   parameter logic [31:0] DEF_CAP    = 32'h0010_0000,
   parameter int          ADDR4_LOG2 = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              spi_sel_o,
   output logic              spi_req_o,
   output logic [7:0]        spi_tx_o,
   input  logic [7:0]        spi_rx_i,
   input  logic              spi_done_i,
   output logic              done_o,
   output logic [1:0]        err_o,
   output logic [PAGE_W-1:0] page_size_o,
   output logic [31:0]       capacity_o,
   output logic              addr4_o
);
   localparam int          AW       = 24;
   localparam logic [31:0] A4_LIMIT = 32'd1 << ADDR4_LOG2;
   localparam logic        DEF_A4   = (DEF_CAP > A4_LIMIT);

   if (ADDR4_LOG2 < 1 || ADDR4_LOG2 > 31) begin : g_bad_a4
      initial $error("sfdp_probe: ADDR4_LOG2 out of range");
   end

   probe_st_e     st;
   logic          go_q;
   logic [AW-1:0] rd_addr;
   logic          rd_fin;
   logic [31:0]   rd_dw;
   logic [7:0]    main_major, main_minor;
   logic [8:0]    remain;
   logic [AW-1:0] hoff;
   logic [23:0]   ph_lo;
   logic          found;
   logic [7:0]    best_min;
   logic [23:0]   best_ptr;
   logic          pg_gran;
   logic [3:0]    pg_exp;

   sfdp_dword_rd #(.AW(AW)) rd_i (
      .clk(clk), .rst_n(rst_n), .go_i(go_q), .addr_i(rd_addr),
      .sel_o(spi_sel_o), .req_o(spi_req_o), .tx_o(spi_tx_o),
      .rx_i(spi_rx_i), .done_i(spi_done_i), .fin_o(rd_fin), .dw_o(rd_dw)
   );

   logic        acc;
   logic [7:0]  acc_min;
   logic [23:0] acc_ptr;

   sfdp_hdr_eval hdr_i (
      .main_major_i(main_major), .main_minor_i(main_minor),
      .ph_lo_i(ph_lo), .ph_hi_i(rd_dw), .best_minor_i(best_min),
      .accept_o(acc), .tbl_minor_o(acc_min), .tbl_ptr_o(acc_ptr)
   );

   logic              nx_found;
   logic [7:0]        nx_min;
   logic [23:0]       nx_ptr;
   assign nx_found = found | acc;
   assign nx_min   = acc ? acc_min : best_min;
   assign nx_ptr   = acc ? acc_ptr : best_ptr;

   logic [PAGE_W-1:0] dec_page;
   logic [31:0]       dec_cap;
   logic              dec_ovf;

   sfdp_bfpt_dec #(.PAGE_W(PAGE_W)) dec_i (
      .tbl_minor_i(best_min), .gran_i(pg_gran), .page_exp_i(pg_exp),
      .dens_i(rd_dw), .page_o(dec_page), .cap_o(dec_cap), .ovf_o(dec_ovf)
   );

   logic              term;
   probe_err_e        term_err;
   logic [PAGE_W-1:0] term_page;
   logic [31:0]       term_cap;

   always_comb begin
      term     = 1'b0;
      term_err = PERR_NONE;
      if (rd_fin) begin
         unique case (st)
            PS_HDR1:  if (rd_dw != DISC_SIG) begin term = 1'b1; term_err = PERR_SIG; end
            PS_PH2:   if (remain == 9'd1 && !nx_found) begin term = 1'b1; term_err = PERR_NOTBL; end
            PS_TDENS: begin term = 1'b1; term_err = dec_ovf ? PERR_OVF : PERR_NONE; end
            default:  ;
         endcase
      end
      term_page = (term_err == PERR_NONE) ? dec_page : PAGE_W'(DEF_PAGE);
      term_cap  = (term_err == PERR_NONE) ? dec_cap  : DEF_CAP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o      <= 1'b0;
         err_o       <= PERR_NONE;
         page_size_o <= PAGE_W'(DEF_PAGE);
         capacity_o  <= DEF_CAP;
         addr4_o     <= DEF_A4;
      end else begin
         done_o <= term;
         if (term) begin
            err_o       <= term_err;
            page_size_o <= term_page;
            capacity_o  <= term_cap;
            addr4_o     <= (term_cap > A4_LIMIT);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= PS_IDLE;  go_q <= 1'b0;  rd_addr <= '0;
         main_major <= '0;  main_minor <= '0;  remain <= '0;  hoff <= '0;
         ph_lo <= '0;  found <= 1'b0;  best_min <= '0;  best_ptr <= '0;
         pg_gran <= 1'b0;  pg_exp <= '0;
      end else begin
         go_q <= 1'b0;
         if (term) begin
            st <= PS_IDLE;
         end else begin
            unique case (st)
               PS_IDLE: if (start_i) begin
                  go_q <= 1'b1;  rd_addr <= '0;  st <= PS_HDR1;
                  found <= 1'b0;  best_min <= '0;  best_ptr <= '0;
               end
               PS_HDR1: if (rd_fin) begin
                  go_q <= 1'b1;  rd_addr <= AW'(4);  st <= PS_HDR2;
               end
               PS_HDR2: if (rd_fin) begin
                  main_minor <= rd_dw[7:0];
                  main_major <= rd_dw[15:8];
                  remain     <= {1'b0, rd_dw[23:16]} + 9'd1;
                  hoff       <= AW'(8);
                  go_q <= 1'b1;  rd_addr <= AW'(8);  st <= PS_PH1;
               end
               PS_PH1: if (rd_fin) begin
                  ph_lo <= rd_dw[23:0];
                  go_q <= 1'b1;  rd_addr <= hoff + AW'(4);  st <= PS_PH2;
               end
               PS_PH2: if (rd_fin) begin
                  found    <= nx_found;
                  best_min <= nx_min;
                  best_ptr <= nx_ptr;
                  remain   <= remain - 9'd1;
                  hoff     <= hoff + AW'(8);
                  go_q     <= 1'b1;
                  if (remain == 9'd1) begin
                     rd_addr <= (nx_min < REV_SPLIT) ? nx_ptr : nx_ptr + AW'(40);
                     st      <= PS_TPAGE;
                  end else begin
                     rd_addr <= hoff + AW'(8);
                     st      <= PS_PH1;
                  end
               end
               PS_TPAGE: if (rd_fin) begin
                  pg_gran <= rd_dw[2];
                  pg_exp  <= rd_dw[7:4];
                  go_q <= 1'b1;  rd_addr <= best_ptr + AW'(4);  st <= PS_TDENS;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/sfdp_probe_chk.sv
module sfdp_probe_chk #(
   parameter int          PAGE_W     = 16,
   parameter int          DEF_PAGE   = 256,
   parameter logic [31:0] DEF_CAP    = 32'h0010_0000,
   parameter int          ADDR4_LOG2 = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic [1:0]        err,
   input logic [PAGE_W-1:0] page,
   input logic [31:0]       cap,
   input logic              addr4,
   input logic              sel,
   input logic              req
);
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(page) && $stable(cap) && $stable(addr4) && $stable(err)));

   // R6
   err_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err != 2'd0) |-> (page == PAGE_W'(DEF_PAGE) && cap == DEF_CAP));

   // R9
   addr4_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr4 == (cap > (32'd1 << ADDR4_LOG2)));

   // R1
   req_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> sel);

endmodule

bind sfdp_probe sfdp_probe_chk #(
   .PAGE_W(PAGE_W), .DEF_PAGE(DEF_PAGE), .DEF_CAP(DEF_CAP), .ADDR4_LOG2(ADDR4_LOG2)
) chk_i (
   .clk(clk), .rst_n(rst_n), .done(done_o), .err(err_o), .page(page_size_o),
   .cap(capacity_o), .addr4(addr4_o), .sel(spi_sel_o), .req(spi_req_o)
);

// File: tb/sfdp_probe_tb_top.sv
`timescale 1ns/1ps
module sfdp_probe_tb_top;

   localparam int          PW    = 16;
   localparam logic [15:0] DPAGE = 16'd256;
   localparam logic [31:0] DCAP  = 32'h0010_0000;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, start, sel, req, sdone, done, a4;
   logic [7:0] tx, rx;
   logic [1:0] err;
   logic [PW-1:0] page;
   logic [31:0] cap;

   sfdp_probe #(.PAGE_W(PW), .DEF_PAGE(256), .DEF_CAP(DCAP), .ADDR4_LOG2(24)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .spi_sel_o(sel), .spi_req_o(req),
      .spi_tx_o(tx), .spi_rx_i(rx), .spi_done_i(sdone), .done_o(done),
      .err_o(err), .page_size_o(page), .capacity_o(cap), .addr4_o(a4)
   );

   int nchk = 0, nerr = 0;
   logic [7:0]  mem [0:255];
   logic [23:0] rd_log [0:31];
   int nrd, frame_err, pos;
   logic [23:0] cur;

   // flash model: answers one byte every other cycle, driven on the falling edge
   always @(negedge clk) begin
      if (!rst_n || !sel) begin
         sdone = 1'b0;  pos = 0;
      end else if (sdone) begin
         sdone = 1'b0;
      end else if (req) begin
         case (pos)
            0: if (tx !== 8'h5A) frame_err++;
            1: cur[23:16] = tx;
            2: cur[15:8]  = tx;
            3: cur[7:0]   = tx;
            4: begin
               if (tx !== 8'h00) frame_err++;
               if (nrd < 32) rd_log[nrd] = cur;
               nrd++;
            end
            default: rx = mem[8'(cur + 24'(pos - 5))];
         endcase
         if (pos > 8) frame_err++;
         pos++;
         sdone = 1'b1;
      end
   end

   task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
   endtask

   task automatic put_dw(input int a, input logic [31:0] v);
      for (int i = 0; i < 4; i++) mem[a+i] = v[8*i +: 8];
   endtask

   task automatic put_hdr(input logic [7:0] mn, input logic [7:0] mj, input logic [7:0] cnt);
      put_dw(0, 32'h5044_4653);
      put_dw(4, {8'hFF, cnt, mj, mn});
   endtask

   task automatic put_ph(input int off, input logic [7:0] idlo, input logic [7:0] mn,
                         input logic [7:0] mj, input logic [23:0] ptr, input logic [7:0] idhi);
      put_dw(off, {8'd16, mj, mn, idlo});
      put_dw(off + 4, {idhi, ptr});
   endtask

   task automatic run_probe(input string rq);
      int w;
      nrd = 0;  frame_err = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      w = 0;
      while (!done && w < 5000) begin
         @(negedge clk);
         w++;
      end
      check({rq, " run completes"}, 64'(w < 5000), 64'd1);
      check("R1 frame opcode/dummy/length", 64'(frame_err), 64'd0);
   endtask

   task automatic expect_out(input string rq, input logic [1:0] e, input logic [15:0] p,
                             input logic [31:0] c, input logic m);
      check({rq, " err"},      64'(err),  64'(e));
      check({rq, " page"},     64'(page), 64'(p));
      check({rq, " capacity"}, 64'(cap),  64'(c));
      check({rq, " R9 mode"},  64'(a4),   64'(m));
   endtask

   typedef struct packed {
      logic [7:0]  smin;
      logic [7:0]  tmin;
      logic [31:0] dw1;
      logic [31:0] dw11;
      logic [31:0] dw2;
      logic [15:0] pg;
      logic [31:0] cp;
      logic        md;
      logic [1:0]  er;
   } vec_t;

   localparam vec_t VT [0:5] = '{
      '{8'd0, 8'd0, 32'h4, 32'h0,  32'h00FF_FFFF, 16'd64,  32'h0020_0000, 1'b0, 2'd0},
      '{8'd0, 8'd3, 32'h0, 32'hF0, 32'h8000_001B, 16'd1,   32'h0100_0000, 1'b0, 2'd0},
      '{8'd6, 8'd6, 32'h4, 32'h80, 32'h8000_001C, 16'd256, 32'h0200_0000, 1'b1, 2'd0},
      '{8'd5, 8'd5, 32'h0, 32'h00, 32'h8000_0022, 16'd1,   32'h8000_0000, 1'b1, 2'd0},
      '{8'd0, 8'd0, 32'h4, 32'h0,  32'h8000_0023, 16'd256, 32'h0010_0000, 1'b0, 2'd3},
      '{8'd0, 8'd1, 32'h4, 32'h0,  32'h7FFF_FFFF, 16'd64,  32'h1000_0000, 1'b1, 2'd0}
   };

   initial begin
      #800000;
      nerr++;  nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      rst_n = 1'b0;  start = 1'b0;  sdone = 1'b0;  rx = 8'h00;
      nrd = 0;  frame_err = 0;  pos = 0;  cur = '0;
      clear_mem();
      repeat (4) @(negedge clk);
      // R10 reset state
      check("R10 reset done", 64'(done), 64'd0);
      check("R1 reset sel",   64'(sel),  64'd0);
      expect_out("R10 reset", 2'd0, DPAGE, DCAP, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // single-header vectors: R7 R8 R9 R3
      for (int v = 0; v < 6; v++) begin
         clear_mem();
         put_hdr(VT[v].smin, 8'd1, 8'd0);
         put_ph(8, 8'h00, VT[v].tmin, 8'd1, 24'h40, 8'hFF);
         put_dw(8'h40, VT[v].dw1);
         put_dw(8'h44, VT[v].dw2);
         put_dw(8'h68, VT[v].dw11);
         run_probe("R8 vector");
         expect_out("R7 R8 vector", VT[v].er, VT[v].pg, VT[v].cp, VT[v].md);
         check("R3 read count", 64'(nrd), 64'd6);
         check("R3 header addrs", {16'(rd_log[0]), 16'(rd_log[1]), 16'(rd_log[2]), 16'(rd_log[3])},
               {16'h0, 16'h4, 16'h8, 16'hC});
         check("R7 page dword addr", 64'(rd_log[4]), (VT[v].tmin < 5) ? 64'h40 : 64'h68);
         check("R8 density addr", 64'(rd_log[5]), 64'h44);
         @(negedge clk);
         check("R10 done single pulse", 64'(done), 64'd0);
      end

      // R2 bad signature
      clear_mem();
      put_hdr(8'd0, 8'd1, 8'd0);
      put_dw(0, 32'h5044_4654);
      put_ph(8, 8'h00, 8'd0, 8'd1, 24'h40, 8'hFF);
      run_probe("R2");
      expect_out("R2 bad signature", 2'd1, DPAGE, DCAP, 1'b0);
      check("R2 single read", 64'(nrd), 64'd1);

      // R5 R4 four headers: foreign ID, major 2, equal revision replaces
      clear_mem();
      put_hdr(8'd0, 8'd1, 8'd3);
      put_ph(8,  8'h00, 8'd2, 8'd1, 24'h40, 8'hFF);
      put_ph(16, 8'h01, 8'd7, 8'd1, 24'h80, 8'hFF);
      put_ph(24, 8'h00, 8'd9, 8'd2, 24'hA0, 8'hFF);
      put_ph(32, 8'h00, 8'd2, 8'd1, 24'hC0, 8'hFF);
      put_dw(8'h40, 32'h0); put_dw(8'h44, 32'h8000_0014);
      put_dw(8'h80, 32'h0); put_dw(8'h84, 32'h8000_0010);
      put_dw(8'hA0, 32'h0); put_dw(8'hA4, 32'h8000_0011);
      put_dw(8'hC0, 32'h4); put_dw(8'hC4, 32'h8000_001E);
      run_probe("R5");
      expect_out("R5 equal revision replaces", 2'd0, 16'd64, 32'h0800_0000, 1'b1);
      check("R3 four-header read count", 64'(nrd), 64'd12);
      check("R5 chosen table addr", 64'(rd_log[10]), 64'hC0);

      // R5 later lower revision ignored
      clear_mem();
      put_hdr(8'd0, 8'd1, 8'd1);
      put_ph(8,  8'h00, 8'd3, 8'd1, 24'h40, 8'hFF);
      put_ph(16, 8'h00, 8'd1, 8'd1, 24'hC0, 8'hFF);
      put_dw(8'h40, 32'h0); put_dw(8'h44, 32'h8000_0014);
      put_dw(8'hC0, 32'h4); put_dw(8'hC4, 32'h8000_001E);
      run_probe("R5");
      expect_out("R5 lower revision skipped", 2'd0, 16'd1, 32'h0002_0000, 1'b0);
      check("R5 kept table addr", 64'(rd_log[6]), 64'h40);

      // R4 R6 high ID byte mismatch under minor >= 5
      clear_mem();
      put_hdr(8'd5, 8'd1, 8'd0);
      put_ph(8, 8'h00, 8'd5, 8'd1, 24'h40, 8'h00);
      put_dw(8'h40, 32'h4); put_dw(8'h44, 32'h8000_001E);
      run_probe("R4");
      expect_out("R4 R6 id high mismatch", 2'd2, DPAGE, DCAP, 1'b0);
      check("R6 no table reads", 64'(nrd), 64'd4);

      // R4 R6 main major revision 2
      clear_mem();
      put_hdr(8'd0, 8'd2, 8'd0);
      put_ph(8, 8'h00, 8'd0, 8'd1, 24'h40, 8'hFF);
      run_probe("R4");
      expect_out("R4 R6 main major 2", 2'd2, DPAGE, DCAP, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule